// File: doc/BRIEF.md
# One-Wire Search ROM Accelerator

This engine sits beside a one-wire bus master and resolves one branch of the 64-bit ROM search tree. The host drives the tree walk. The engine decides each ID bit by itself. The host feeds it one byte per nibble of the ID, starting with the least significant nibble, so sixteen byte exchanges cover a whole ID. Each written byte carries four guide bits at its odd positions. The guide bit sets the path only where the devices on the bus disagree.

For each ID bit the engine asks the bus timing engine for three slots, in this order: a read slot for the true bit, a read slot for its complement, and a write slot carrying the bit it chose, so that devices that do not match drop out. When all four bits of a nibble are done, the engine packs a result byte and raises a receive-full flag. In that byte each chosen bit sits on an odd position and its discrepancy flag on the even position just below it.

The engine works only while the search-mode input is high. Lowering that input abandons the current nibble and returns the engine to rest. Sending the search command byte and the host-side bookkeeping between passes are handled elsewhere.

Top module: `search_rom_accel`

## Requirements
- R1: After reset, slot_req is 0, rx_full is 0 and rx_data is 0x00.
- R2: The engine accepts a written byte when wr_en is high, search_en is high and it is idle. It then issues, for nibble bits 0, 1, 2 and 3 in that order, a read slot, a second read slot and a write slot. slot_kind is 0 for a read slot and 1 for a write slot.
- R3: Guide bit k of a written byte is taken from byte position 2k+1. The even positions have no effect on the result.
- R4: When the first read differs from the second read, the chosen bit equals the first read and the discrepancy flag is 0.
- R5: When both reads return 0, the chosen bit equals the guide bit and the discrepancy flag is 1.
- R6: When both reads return 1 (no device answered), the chosen bit and the discrepancy flag are both 1.
- R7: The write slot of each ID bit carries the chosen bit on slot_wbit.
- R8: In rx_data, the chosen bit for nibble bit k sits at position 2k+1 and its discrepancy flag at position 2k.
- R9: rx_full rises only after the write slot of nibble bit 3 has completed and no slot is pending. It falls one cycle after a rd_ack pulse.
- R10: When search_en is low at a clock edge, slot_req and rx_full are 0 after that edge. A later accepted byte starts a fresh nibble at bit 0.
- R11: A byte written while search_en is low, or while a nibble is in progress, is ignored.
- R12: Once slot_req is raised, it stays high with slot_kind and slot_wbit unchanged until slot_done is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| search_en | input | 1 | Search mode enable; low aborts and clears |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte; guide bits at odd positions |
| rd_ack | input | 1 | Host read strobe; clears rx_full |
| rx_data | output | 8 | Result byte: chosen bits odd, discrepancy flags even |
| rx_full | output | 1 | Result byte ready |
| slot_req | output | 1 | Bit-slot request to the bus timing engine |
| slot_kind | output | 1 | 0 = read slot, 1 = write slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | One-cycle pulse: requested slot finished |
| slot_rbit | input | 1 | Bus bit sampled in a read slot, valid with slot_done |

## Verification
The assertions assume that the bus timing engine pulses slot_done for exactly one cycle, only while slot_req is high, and that slot_rbit is valid in that same cycle. They also assume that the host waits for rx_full before it writes the next nibble. The bench's slot responder answers each request after a random delay of one to three cycles, drops slot_done on the next falling edge, and returns read values from per-bit patterns drawn for that nibble. The host-side tasks write only when the engine should be idle, except in the directed cases that write on purpose during a nibble or with the mode off.

// File: rtl/sra_pkg.sv
package sra_pkg;

    localparam int unsigned NIB_W_DEF = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_RD_TRUE = 2'd1,
        SEQ_RD_COMP = 2'd2,
        SEQ_WRITE   = 2'd3
    } seq_state_t;

    typedef enum logic {
        SLOT_READ  = 1'b0,
        SLOT_WRITE = 1'b1
    } slot_kind_t;

    typedef struct packed {
        logic chosen;
        logic disc;
    } bit_result_t;

    // Decide one ID bit from the two read slots and the host guide bit.
    function automatic bit_result_t resolve_bit(input logic true_bit,
                                                input logic comp_bit,
                                                input logic guide_bit);
        bit_result_t r;
        if (true_bit != comp_bit) begin
            r.chosen = true_bit;
            r.disc   = 1'b0;
        end else if (!true_bit) begin
            r.chosen = guide_bit;
            r.disc   = 1'b1;
        end else begin
            r.chosen = 1'b1;
            r.disc   = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/sra_host_port.sv
module sra_host_port
    import sra_pkg::*;
#(
    parameter  int unsigned NIB_W  = NIB_W_DEF,
    localparam int unsigned BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              search_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_ack,
    input  logic              seq_idle,
    input  logic              nib_done,
    input  logic [BYTE_W-1:0] nib_byte,
    output logic              start,
    output logic [NIB_W-1:0]  guide,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full
);

    logic [NIB_W-1:0]  guide_q;
    logic [BYTE_W-1:0] rx_data_q;
    logic              rx_full_q;
    logic              unused_wr_bits;

    // Even positions of the host byte carry nothing.
    assign unused_wr_bits = ^wr_data;

    assign start = wr_en && search_en && seq_idle;

    for (genvar k = 0; k < NIB_W; k++) begin : g_guide
        always_ff @(posedge clk) begin
            if (rst) begin
                guide_q[k] <= 1'b0;
            end else if (start) begin
                guide_q[k] <= wr_data[2*k+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data_q <= '0;
            rx_full_q <= 1'b0;
        end else if (!search_en) begin
            rx_full_q <= 1'b0;
        end else if (nib_done) begin
            rx_data_q <= nib_byte;
            rx_full_q <= 1'b1;
        end else if (rd_ack) begin
            rx_full_q <= 1'b0;
        end
    end

    assign guide   = guide_q;
    assign rx_data = rx_data_q;
    assign rx_full = rx_full_q;

    assert_exit_clear_R10: assert property (@(posedge clk) disable iff (rst)
        !search_en |=> !rx_full_q);

    assert_guide_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(guide_q));

endmodule

// File: rtl/sra_slot_seq.sv
module sra_slot_seq
    import sra_pkg::*;
#(
    parameter  int unsigned NIB_W = NIB_W_DEF,
    localparam int unsigned IDX_W = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              search_en,
    input  logic              start,
    input  logic [NIB_W-1:0]  guide,
    output logic              slot_req,
    output slot_kind_t        slot_kind,
    output logic              slot_wbit,
    input  logic              slot_done,
    input  logic              slot_rbit,
    output logic              idle,
    output logic              bit_valid,
    output logic [IDX_W-1:0]  bit_idx,
    output bit_result_t       bit_res
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIB_W - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             true_q;
    bit_result_t      res_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    if (start)     state_d = SEQ_RD_TRUE;
            SEQ_RD_TRUE: if (slot_done) state_d = SEQ_RD_COMP;
            SEQ_RD_COMP: if (slot_done) state_d = SEQ_WRITE;
            SEQ_WRITE:   if (slot_done) state_d = (idx_q == LAST_IDX) ? SEQ_IDLE : SEQ_RD_TRUE;
            default:                    state_d = SEQ_IDLE;
        endcase
        if (!search_en) begin
            state_d = SEQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            true_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE && start) begin
                idx_q <= '0;
            end
            if (state_q == SEQ_RD_TRUE && slot_done) begin
                true_q <= slot_rbit;
            end
            if (state_q == SEQ_RD_COMP && slot_done) begin
                res_q <= resolve_bit(true_q, slot_rbit, guide[idx_q]);
            end
            if (state_q == SEQ_WRITE && slot_done && idx_q != LAST_IDX) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign slot_req  = (state_q != SEQ_IDLE);
    assign slot_kind = (state_q == SEQ_WRITE) ? SLOT_WRITE : SLOT_READ;
    assign slot_wbit = (state_q == SEQ_WRITE) ? res_q.chosen : 1'b1;
    assign idle      = (state_q == SEQ_IDLE);
    assign bit_valid = (state_q == SEQ_WRITE) && slot_done && search_en;
    assign bit_idx   = idx_q;
    assign bit_res   = res_q;

    assert_slot_hold_R12: assert property (@(posedge clk) disable iff (rst)
        slot_req && !slot_done && search_en |=> slot_req && $stable(slot_kind) && $stable(slot_wbit));

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !search_en |=> !slot_req);

    assert_disagree_R4: assert property (@(posedge clk) disable iff (rst)
        state_q == SEQ_RD_COMP && slot_done && search_en && (true_q != slot_rbit)
        |=> slot_kind == SLOT_WRITE && slot_wbit == $past(true_q));

    assert_both_low_R5: assert property (@(posedge clk) disable iff (rst)
        state_q == SEQ_RD_COMP && slot_done && search_en && !true_q && !slot_rbit
        |=> slot_kind == SLOT_WRITE && slot_wbit == $past(guide[idx_q]) && res_q.disc);

    assert_both_high_R6: assert property (@(posedge clk) disable iff (rst)
        state_q == SEQ_RD_COMP && slot_done && search_en && true_q && slot_rbit
        |=> slot_wbit && res_q.disc);

endmodule

// File: rtl/sra_nibble_acc.sv
module sra_nibble_acc
    import sra_pkg::*;
#(
    parameter  int unsigned NIB_W  = NIB_W_DEF,
    localparam int unsigned BYTE_W = 2 * NIB_W,
    localparam int unsigned IDX_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              search_en,
    input  logic              bit_valid,
    input  logic [IDX_W-1:0]  bit_idx,
    input  bit_result_t       bit_res,
    output logic              nib_done,
    output logic [BYTE_W-1:0] nib_byte
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIB_W - 1);

    logic done_q;

    for (genvar k = 0; k < NIB_W; k++) begin : g_lane
        logic [1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= 2'b00;
            end else if (bit_valid && bit_idx == IDX_W'(k)) begin
                lane_q <= {bit_res.chosen, bit_res.disc};
            end
        end
        assign nib_byte[2*k+1:2*k] = lane_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= search_en && bit_valid && (bit_idx == LAST_IDX);
        end
    end

    assign nib_done = done_q;

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        nib_done |=> !nib_done);

    assert_early_bits_R2: assert property (@(posedge clk) disable iff (rst)
        bit_valid && bit_idx != LAST_IDX |=> !nib_done);

endmodule

// File: rtl/search_rom_accel.sv
module search_rom_accel
    import sra_pkg::*;
#(
    parameter  int unsigned NIB_W  = NIB_W_DEF,
    localparam int unsigned BYTE_W = 2 * NIB_W,
    localparam int unsigned IDX_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              search_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_ack,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              slot_req,
    output logic              slot_kind,
    output logic              slot_wbit,
    input  logic              slot_done,
    input  logic              slot_rbit
);

    logic              start_w;
    logic [NIB_W-1:0]  guide_w;
    logic              idle_w;
    logic              bit_valid_w;
    logic [IDX_W-1:0]  bit_idx_w;
    bit_result_t       bit_res_w;
    logic              nib_done_w;
    logic [BYTE_W-1:0] nib_byte_w;
    slot_kind_t        kind_w;

    sra_host_port #(.NIB_W(NIB_W)) u_host (
        .clk       (clk),
        .rst       (rst),
        .search_en (search_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_ack    (rd_ack),
        .seq_idle  (idle_w),
        .nib_done  (nib_done_w),
        .nib_byte  (nib_byte_w),
        .start     (start_w),
        .guide     (guide_w),
        .rx_data   (rx_data),
        .rx_full   (rx_full)
    );

    sra_slot_seq #(.NIB_W(NIB_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .search_en (search_en),
        .start     (start_w),
        .guide     (guide_w),
        .slot_req  (slot_req),
        .slot_kind (kind_w),
        .slot_wbit (slot_wbit),
        .slot_done (slot_done),
        .slot_rbit (slot_rbit),
        .idle      (idle_w),
        .bit_valid (bit_valid_w),
        .bit_idx   (bit_idx_w),
        .bit_res   (bit_res_w)
    );

    sra_nibble_acc #(.NIB_W(NIB_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .search_en (search_en),
        .bit_valid (bit_valid_w),
        .bit_idx   (bit_idx_w),
        .bit_res   (bit_res_w),
        .nib_done  (nib_done_w),
        .nib_byte  (nib_byte_w)
    );

    assign slot_kind = kind_w;

    assert_full_after_nibble_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> !slot_req);

endmodule

// File: tb/tb_search_rom_accel.sv
`timescale 1ns/1ps
module tb_search_rom_accel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       search_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       slot_req;
    logic       slot_kind;
    logic       slot_wbit;
    logic       slot_done = 1'b0;
    logic       slot_rbit = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [3:0] pat_t, pat_c, exp_ch;
    int rsp_bit, rsp_phase, rsp_cnt, rsp_lat;

    always #2 clk = ~clk;

    search_rom_accel dut (
        .clk(clk), .rst(rst), .search_en(search_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_ack(rd_ack), .rx_data(rx_data), .rx_full(rx_full), .slot_req(slot_req),
        .slot_kind(slot_kind), .slot_wbit(slot_wbit), .slot_done(slot_done), .slot_rbit(slot_rbit)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte(input logic [7:0] wb, input logic [3:0] t, input logic [3:0] c);
        logic [7:0] r;
        r = 8'h00;
        for (int k = 0; k < 4; k++) begin
            if (t[k] != c[k]) begin
                r[2*k+1] = t[k];  r[2*k] = 1'b0;
            end else if (!t[k]) begin
                r[2*k+1] = wb[2*k+1];  r[2*k] = 1'b1;
            end else begin
                r[2*k+1] = 1'b1;  r[2*k] = 1'b1;
            end
        end
        return r;
    endfunction

    // Bus timing engine model: answers each slot after rsp_lat cycles.
    initial begin
        rsp_cnt = 0; rsp_bit = 0; rsp_phase = 0; rsp_lat = 1;
        forever begin
            @(negedge clk);
            if (slot_done) begin
                slot_done = 1'b0;
                rsp_cnt = 0;
            end else if (!slot_req) begin
                rsp_cnt = 0;
            end else begin
                rsp_cnt++;
                if (rsp_cnt >= rsp_lat) begin
                    if (rsp_bit > 3) begin
                        check(1'b0, "R2 extra slot", 32'(rsp_bit), 32'd3);
                        slot_rbit = 1'b1;
                    end else begin
                        check(slot_kind == (rsp_phase == 2), "R2 slot kind", 32'(slot_kind), 32'(rsp_phase == 2));
                        if (rsp_phase == 0) slot_rbit = pat_t[rsp_bit];
                        else if (rsp_phase == 1) slot_rbit = pat_c[rsp_bit];
                        else begin
                            check(slot_wbit == exp_ch[rsp_bit], "R7 write slot bit", 32'(slot_wbit), 32'(exp_ch[rsp_bit]));
                            slot_rbit = 1'b1;
                        end
                    end
                    slot_done = 1'b1;
                    if (rsp_phase == 2) begin
                        rsp_phase = 0;
                        rsp_bit++;
                    end else begin
                        rsp_phase++;
                    end
                end
            end
        end
    end

    task automatic arm(input logic [7:0] wb, input logic [3:0] t, input logic [3:0] c);
        logic [7:0] m;
        m = model_byte(wb, t, c);
        pat_t = t; pat_c = c;
        for (int k = 0; k < 4; k++) exp_ch[k] = m[2*k+1];
        rsp_bit = 0; rsp_phase = 0;
        rsp_lat = 1 + int'($urandom % 3);
    endtask

    task automatic run_nibble(input logic [7:0] wb, input logic [3:0] t, input logic [3:0] c,
                              input bit busy_write, input bit do_ack, input string tag);
        bit early;
        bit seen;
        early = 1'b0; seen = 1'b0;
        arm(wb, t, c);
        @(negedge clk); wr_en = 1'b1; wr_data = wb;
        @(negedge clk); wr_en = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (busy_write && i == 4) begin
                wr_en = 1'b1; wr_data = ~wb;
            end else begin
                wr_en = 1'b0;
            end
            if (rx_full && slot_req) early = 1'b1;
            if (rx_full) begin seen = 1'b1; break; end
        end
        wr_en = 1'b0;
        check(seen && !early, {"R9 ready after last slot ", tag}, 32'(seen), 32'd1);
        check(rsp_bit == 4 && rsp_phase == 0, {"R2 slot count ", tag}, 32'(rsp_bit * 3 + rsp_phase), 32'd12);
        check(rx_data == model_byte(wb, t, c), {"R8 result byte ", tag}, 32'(rx_data), 32'(model_byte(wb, t, c)));
        if (do_ack) begin
            @(negedge clk); rd_ack = 1'b1;
            @(negedge clk); rd_ack = 1'b0;
            check(!rx_full, "R9 cleared by ack", 32'(rx_full), 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!slot_req, "R1 slot_req idle", 32'(slot_req), 32'd0);
        check(!rx_full, "R1 rx_full clear", 32'(rx_full), 32'd0);
        check(rx_data == 8'h00, "R1 rx_data zero", 32'(rx_data), 32'd0);

        // R11: write with mode off is ignored
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hAA;
        @(negedge clk); wr_en = 1'b0; search_en = 1'b1;
        begin
            bit any;
            any = 1'b0;
            repeat (8) begin @(negedge clk); if (slot_req || rx_full) any = 1'b1; end
            check(!any, "R11 write with mode off ignored", 32'(any), 32'd0);
        end

        run_nibble(8'h00, 4'b1010, 4'b0101, 1'b0, 1'b1, "R4");
        check(rx_data == 8'h88, "R4 disagree byte", 32'(rx_data), 32'h88);
        run_nibble(8'hAA, 4'b0000, 4'b0000, 1'b0, 1'b1, "R5 guide ones");
        check(rx_data == 8'hFF, "R5 guide ones byte", 32'(rx_data), 32'hFF);
        run_nibble(8'h8A, 4'b0000, 4'b0000, 1'b0, 1'b1, "R5 mixed guide");
        check(rx_data == 8'hDF, "R5 mixed guide byte", 32'(rx_data), 32'hDF);
        run_nibble(8'h55, 4'b0000, 4'b0000, 1'b0, 1'b1, "R3 even bits");
        check(rx_data == 8'h55, "R3 even bits no effect", 32'(rx_data), 32'h55);
        run_nibble(8'h00, 4'b1111, 4'b1111, 1'b0, 1'b1, "R6");
        check(rx_data == 8'hFF, "R6 no device byte", 32'(rx_data), 32'hFF);
        run_nibble(8'h00, 4'b0000, 4'b0000, 1'b1, 1'b1, "R11 busy write");
        check(rx_data == 8'h55, "R11 busy write ignored", 32'(rx_data), 32'h55);

        // R10: abort in the middle of a nibble
        arm(8'h00, 4'b1100, 4'b0011);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk); wr_en = 1'b0;
        repeat (5) @(negedge clk);
        search_en = 1'b0;
        @(negedge clk);
        check(!slot_req, "R10 abort drops slot_req", 32'(slot_req), 32'd0);
        check(!rx_full, "R10 abort no result", 32'(rx_full), 32'd0);
        repeat (3) @(negedge clk);
        search_en = 1'b1;
        run_nibble(8'hA0, 4'b0110, 4'b0100, 1'b0, 1'b1, "R10 restart");

        // R10: mode exit clears a pending result
        run_nibble(8'h02, 4'b0001, 4'b0000, 1'b0, 1'b0, "R10 pending");
        @(negedge clk); search_en = 1'b0;
        @(negedge clk);
        check(!rx_full, "R10 exit clears rx_full", 32'(rx_full), 32'd0);
        @(negedge clk); search_en = 1'b1;

        // R2: full 64-bit IDs as 16 random nibble exchanges each
        for (int id = 0; id < 3; id++) begin
            for (int n = 0; n < 16; n++) begin
                logic [7:0] wb;
                logic [3:0] t, c;
                wb = 8'($urandom);
                t  = 4'($urandom);
                c  = 4'($urandom);
                run_nibble(wb, t, c, 1'b0, 1'b1, "R2 random sweep");
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule